// File: doc/BRIEF.md
# One-of-Four Transition-Signaling Channel Encoder

This block is the sending end of a four-wire, two-phase, delay-insensitive link. Each transfer carries one 2-bit symbol. The four wires are never returned to zero. Every transfer flips exactly one wire. The total weight of the wire word therefore changes parity on every transfer, so the parity gives the phase. Inside each phase, the wire levels alone identify the symbol.

The block keeps the present wire word in a register. For each of the four single-wire flips it decodes the resulting word, and it applies the one flip that decodes to the requested symbol.

The local side offers symbols through a valid/ready handshake. The far side replies with a single acknowledge level that toggles once for each word it takes in. The block will not send another word until that toggle has been seen.

Top module: `lets4_chan_enc`

## Requirements
- R1: When reset is high at a clock edge, the wires go to 0000 (even phase). While no transfer is in flight, ready is 1 and code_err is 0.
- R2: Each accepted transfer (sym_valid and sym_ready both high at a clock edge) changes exactly one of the four wires at that same edge.
- R3: After a transfer, the wire word decodes to the accepted symbol. The wire word is written rails[3:0].
  - Odd weight: symbol k is the word that is one-hot at bit 3-k, or the word that is one-cold at bit 3-k.
  - Even weight: symbol 0 is 0000/1111, symbol 1 is 0011/1100, symbol 2 is 0101/1010, symbol 3 is 0110/1001.
- R4: Weight parity alternates on every transfer. The first transfer after reset lands on an odd-weight word.
- R5: sym_ready goes low from the clock edge of a transfer. It comes back in the cycle after the first clock edge at which ack_in is seen toggled.
- R6: A symbol offered while sym_ready is low has no effect: the wires keep their value.
- R7: While sym_valid is low, the wires hold their value.
- R8: code_err is 0 in every state the block can reach. It would go to 1 if the number of candidate flips that match the requested symbol were anything other than exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sym_valid | input | 1 | A symbol is being offered |
| sym_data | input | 2 | The offered symbol |
| sym_ready | output | 1 | The block can take a symbol now |
| ack_in | input | 1 | Two-phase acknowledge from the receiver; one toggle per word taken |
| rails | output | 4 | Channel wires, registered |
| code_err | output | 1 | Self-check: the flip selection found zero candidates or more than one |

## Verification
A wrong wire register shows on the rails output at the clock edge that caused it. That edge is the one where the symbol was accepted.

The possible faults each show up in a distinct way:
- A wrong bit choice gives a word that decodes to the wrong symbol.
- Two flips give a word whose parity does not change.
- A missed flip gives a word that stays where it was.

A broken acknowledge tracker shows up on sym_ready, in the cycle right after the transfer or right after the acknowledge toggle. The bench therefore compares both outputs against its own table model after every transfer and after every acknowledge.

// File: rtl/lets4_pkg.sv
package lets4_pkg;

    localparam int RAILS = 4;
    localparam int SYM_W = 2;

    typedef logic [RAILS-1:0] rails_t;
    typedef logic [SYM_W-1:0] sym_t;

    typedef struct packed {
        logic odd;
        sym_t sym;
    } dec_t;

    // Decode a wire word into its phase and symbol.
    function automatic dec_t decode_rails(input rails_t r);
        dec_t   d;
        rails_t n;
        d.odd = ^r;
        d.sym = '0;
        if (d.odd) begin
            // Put the word in one-hot form: a one-cold word is complemented.
            n = ($countones(r) == 1) ? r : ~r;
            for (int i = 0; i < RAILS; i++) begin
                if (n[i]) d.sym = sym_t'(RAILS - 1 - i);
            end
        end else begin
            // Fold out the complement with the top wire, then read the two middle wires.
            d.sym = {r[2] ^ r[3], r[1] ^ r[3]};
        end
        return d;
    endfunction

endpackage

// File: rtl/lets4_decode.sv
module lets4_decode
    import lets4_pkg::*;
(
    input  rails_t word_i,
    output dec_t   dec_o
);
    assign dec_o = decode_rails(word_i);
endmodule

// File: rtl/lets4_flip_select.sv
module lets4_flip_select
    import lets4_pkg::*;
(
    input  rails_t cur_i,
    input  sym_t   want_i,
    output rails_t next_o,
    output logic   err_o
);
    rails_t hit;
    logic   cur_odd;

    assign cur_odd = ^cur_i;

    for (genvar i = 0; i < RAILS; i++) begin : g_cand
        rails_t cand;
        dec_t   cand_dec;
        assign cand = cur_i ^ rails_t'(1 << i);
        lets4_decode dec_i (.word_i(cand), .dec_o(cand_dec));
        assign hit[i] = (cand_dec.sym == want_i) && (cand_dec.odd != cur_odd);
    end

    assign err_o  = (hit == '0) || ((hit & (hit - rails_t'(1))) != '0);
    assign next_o = cur_i ^ hit;
endmodule

// File: rtl/lets4_ack_track.sv
module lets4_ack_track (
    input  logic clk,
    input  logic rst,
    input  logic ack_i,
    input  logic phase_i,
    output logic free_o
);
    logic ack_q;

    always_ff @(posedge clk) begin
        if (rst) ack_q <= 1'b0;
        else     ack_q <= ack_i;
    end

    // No word is in flight when the seen acknowledge level equals the wire phase.
    assign free_o = (ack_q == phase_i);
endmodule

// File: rtl/lets4_chan_enc.sv
module lets4_chan_enc
    import lets4_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sym_valid,
    input  logic [1:0] sym_data,
    output logic       sym_ready,
    input  logic       ack_in,
    output logic [3:0] rails,
    output logic       code_err
);
    rails_t rails_q;
    rails_t rails_nxt;
    logic   sel_err;
    logic   fire;

    lets4_flip_select sel_i (
        .cur_i  (rails_q),
        .want_i (sym_t'(sym_data)),
        .next_o (rails_nxt),
        .err_o  (sel_err)
    );

    lets4_ack_track ack_i_trk (
        .clk     (clk),
        .rst     (rst),
        .ack_i   (ack_in),
        .phase_i (^rails_q),
        .free_o  (sym_ready)
    );

    assign fire = sym_valid && sym_ready;

    always_ff @(posedge clk) begin
        if (rst)       rails_q <= '0;
        else if (fire) rails_q <= rails_nxt;
    end

    assign rails    = rails_q;
    assign code_err = sel_err && sym_valid;
endmodule

// File: rtl/lets4_chan_enc_chk.sv
module lets4_chan_enc_chk
    import lets4_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       sym_valid,
    input logic [1:0] sym_data,
    input logic       sym_ready,
    input logic [3:0] rails,
    input logic       code_err
);
    dec_t now_d;
    assign now_d = decode_rails(rails);

    assert_one_flip_R2: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && sym_ready) |=> ($countones(rails ^ $past(rails)) == 1));

    assert_decodes_R3: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && sym_ready) |=> (now_d.sym == $past(sym_data)));

    assert_phase_flip_R4: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && sym_ready) |=> ((^rails) != $past(^rails)));

    assert_busy_after_send_R5: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && sym_ready) |=> !sym_ready);

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !(sym_valid && sym_ready) |=> $stable(rails));

    assert_no_err_R8: assert property (@(posedge clk) disable iff (rst)
        !code_err);
endmodule

bind lets4_chan_enc lets4_chan_enc_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .sym_valid (sym_valid),
    .sym_data  (sym_data),
    .sym_ready (sym_ready),
    .rails     (rails),
    .code_err  (code_err)
);

// File: tb/lets4_chan_enc_tb_top.sv
`timescale 1ns/1ps
module lets4_chan_enc_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sym_valid = 1'b0;
    logic [1:0] sym_data = 2'd0;
    logic       sym_ready;
    logic       ack_in = 1'b0;
    logic [3:0] rails;
    logic       code_err;

    int checks = 0;
    int errors = 0;
    logic [3:0] model_w = 4'b0000;

    always #10 clk = ~clk;

    lets4_chan_enc dut_i (
        .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_data(sym_data),
        .sym_ready(sym_ready), .ack_in(ack_in), .rails(rails), .code_err(code_err)
    );

    // Table of the code, written out from the requirement text.
    function automatic logic [1:0] tbl_sym(input logic [3:0] w);
        case (w)
            4'b1000, 4'b0111, 4'b0000, 4'b1111: return 2'd0;
            4'b0100, 4'b1011, 4'b0011, 4'b1100: return 2'd1;
            4'b0010, 4'b1101, 4'b0101, 4'b1010: return 2'd2;
            default:                            return 2'd3;
        endcase
    endfunction

    function automatic logic [3:0] model_next(input logic [3:0] w, input logic [1:0] s);
        logic [3:0] r;
        r = w;
        for (int i = 0; i < 4; i++) begin
            if (tbl_sym(w ^ (4'b0001 << i)) == s) r = w ^ (4'b0001 << i);
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic t_reset_state;
        rst = 1'b1; ack_in = 1'b0; sym_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_w = 4'b0000;
        @(negedge clk);
        chk(rails == 4'b0000, "R1", "rails after reset", rails, 4'b0000);
        chk(sym_ready == 1'b1, "R1", "ready after reset", sym_ready, 1);
        chk(code_err == 1'b0, "R1", "err after reset", code_err, 0);
    endtask

    task automatic do_send(input logic [1:0] s);
        logic [3:0] exp;
        exp = model_next(model_w, s);
        chk(sym_ready == 1'b1, "R5", "ready before send", sym_ready, 1);
        sym_valid = 1'b1; sym_data = s;
        chk(code_err == 1'b0, "R8", "err while offered", code_err, 0);
        @(negedge clk);
        sym_valid = 1'b0;
        chk(rails == exp, "R3", "codeword", rails, exp);
        chk($countones(rails ^ model_w) == 1, "R2", "one wire flips", rails ^ model_w, 0);
        chk((^rails) != (^model_w), "R4", "phase alternates", ^rails, ~(^model_w));
        chk(sym_ready == 1'b0, "R5", "busy after send", sym_ready, 0);
        model_w = exp;
    endtask

    task automatic do_ack;
        ack_in = ~ack_in;
        chk(sym_ready == 1'b0, "R5", "still busy at ack toggle", sym_ready, 0);
        @(negedge clk);
        chk(sym_ready == 1'b1, "R5", "ready after ack", sym_ready, 1);
    endtask

    task automatic t_first_odd;
        do_send(2'd2);
        chk(rails == 4'b0010, "R4", "first send odd weight", rails, 4'b0010);
        do_ack();
    endtask

    task automatic t_blocked;
        do_send(2'd1);
        for (int k = 0; k < 3; k++) begin
            sym_valid = 1'b1; sym_data = 2'(k);
            @(negedge clk);
            chk(rails == model_w, "R6", "offer while busy ignored", rails, model_w);
        end
        sym_valid = 1'b0;
        do_ack();
    endtask

    task automatic t_idle;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(rails == model_w, "R7", "hold while idle", rails, model_w);
        end
    endtask

    task automatic t_walk;
        for (int i = 0; i < 48; i++) begin
            do_send(2'((i * 3 + i / 4) % 4));
            do_ack();
        end
    endtask

    task automatic t_repeat_same;
        for (int i = 0; i < 6; i++) begin
            do_send(2'd3);
            do_ack();
        end
    endtask

    task automatic t_mid_reset;
        do_send(2'd0);
        t_reset_state();
        do_send(2'd1);
        chk(rails == 4'b0100, "R1", "send after mid reset", rails, 4'b0100);
        do_ack();
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset_state();
        t_first_odd();
        t_idle();
        t_blocked();
        t_walk();
        t_repeat_same();
        t_mid_reset();
        t_idle();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule